// File: doc/BRIEF.md
# Compressed Vertex Index Stream Decoder

This block turns a packed bitstream of variable-length symbols back into a stream of full vertex indices, producing one index per decoded symbol. Each symbol is read through a loadable lookup table and falls into one of three kinds. A cache-slot reference names a position in a small FIFO of recently introduced indices. A first-use marker hands out the next number from a running counter. A reload marker is followed by an explicit index field whose width follows the counter's current value.

Words enter through a valid/ready port and are concatenated MSB first into a bit window. The decoder peeks `HMAX` bits, looks up the symbol and its true code length, and consumes only that many bits. The FIFO holds indices only. It must have the same `K` entries the encoder assumed, which need not match the depth of the vertex cache the indices later feed. Software fills the code table through a write port before a mesh is streamed, and a synchronous reset starts a new mesh.

Control is a two-state machine. In `SYM_WAIT` a symbol is decoded as soon as enough bits are buffered. A slot or first-use symbol emits an index and stays in `SYM_WAIT`. A reload symbol takes the transition *to_field* into `FIELD_WAIT`. There the block waits for the explicit field, emits it, and takes the transition *field_done* back to `SYM_WAIT`. Reset forces `SYM_WAIT`.

Top module: `vid_index_decoder`

## Requirements
- R1: The top `HMAX` bits of the window (zero-padded below the buffered bits) address the code table. The entry gives a symbol ID and a length. The symbol is decoded once at least that many bits are buffered, and exactly that many bits are consumed.
- R2: Symbol ID `K` (16) emits the counter value and then increments the counter. The counter is 0 after reset.
- R3: Symbol ID `S` in 0..K-1 emits the index held in FIFO entry `S` and does not change the FIFO.
- R4: Symbol ID `K+1` (17) is followed by a field of `w` bits, MSB first. `w` is ceil(log2 g) for the current counter `g`, with `w` = 1 when `g` is 0 or 1. The field value is emitted.
- R5: The first-use and reload symbols push their emitted index into the FIFO. Entry 0 is the newest and entry `i` is the `i`-th older one. Entries never written read 0, and the oldest entry is dropped once `K` entries are held.
- R6: A slot reference does not change the age of any entry. Repeated hits leave the order of entries as it was.
- R7: Input words are consumed MSB first and concatenated. A code or field that straddles words stalls decoding until the missing bits arrive.
- R8: A synchronous reset clears the counter, the FIFO, the bit window and the output valid flag.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_idx` hold.
- R10: `in_ready` is low while the window (28 bits with default parameters) cannot accept another full word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | IN_W | Next stream word, first bit in the MSB |
| in_valid | input | 1 | Word present |
| in_ready | output | 1 | Window can take a word |
| tbl_we | input | 1 | Code table write strobe |
| tbl_addr | input | HMAX | Code table entry address (peeked bits) |
| tbl_sym | input | SYM_W | Symbol ID written |
| tbl_len | input | LEN_W | Code length written (0 marks an unused entry) |
| out_idx | output | IDX_W | Decoded vertex index |
| out_valid | output | 1 | Index present |
| out_ready | input | 1 | Consumer takes the index |

## Verification
Two things can fall in the same cycle: a word can be appended to the window while a symbol or field is consumed from it, and an output can be taken while the next symbol is decoded into the freed output register. Both are provoked with random gaps on `in_valid` and random `out_ready` over a stream that sweeps every slot and reload field widths from 1 to 6 bits, so many codes straddle word boundaries. Each emitted index is compared in order with a model built from the requirements. A long forced stall then fills the window and checks that `in_ready` drops and the held output stays unchanged.

// File: rtl/vid_pkg.sv
package vid_pkg;
    typedef enum logic {
        SYM_WAIT   = 1'b0,
        FIELD_WAIT = 1'b1
    } dec_state_e;
endpackage

// File: rtl/vid_code_table.sv
module vid_code_table #(
    parameter int HMAX  = 8,
    parameter int SYM_W = 5,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             we,
    input  logic [HMAX-1:0]  waddr,
    input  logic [SYM_W-1:0] wsym,
    input  logic [LEN_W-1:0] wlen,
    input  logic [HMAX-1:0]  raddr,
    output logic [SYM_W-1:0] rsym,
    output logic [LEN_W-1:0] rlen
);
    localparam int DEPTH = 1 << HMAX;

    logic [SYM_W-1:0] sym_mem [DEPTH];
    logic [LEN_W-1:0] len_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            sym_mem[waddr] <= wsym;
            len_mem[waddr] <= wlen;
        end
    end

    assign rsym = sym_mem[raddr];
    assign rlen = len_mem[raddr];
endmodule

// File: rtl/vid_bit_window.sv
module vid_bit_window #(
    parameter int IN_W  = 8,
    parameter int BUF_W = 28,
    parameter int TOP_W = 20,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [CNT_W-1:0] take_n,
    output logic [TOP_W-1:0] win_top,
    output logic [CNT_W-1:0] avail
);
    localparam int PAD_W = BUF_W - IN_W;

    logic [BUF_W-1:0] bits_q, bits_n, shifted, placed;
    logic [CNT_W-1:0] rem;
    logic             accept;

    assign in_ready = (avail <= CNT_W'(PAD_W));
    assign accept   = in_valid && in_ready;
    assign win_top  = bits_q[BUF_W-1 -: TOP_W];

    always_comb begin
        shifted = bits_q << take_n;
        rem     = avail - take_n;
        placed  = {in_data, {PAD_W{1'b0}}} >> rem;
        bits_n  = accept ? (shifted | placed) : shifted;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
            avail  <= '0;
        end else begin
            bits_q <= bits_n;
            avail  <= accept ? rem + CNT_W'(IN_W) : rem;
        end
    end
endmodule

// File: rtl/vid_index_fifo.sv
module vid_index_fifo #(
    parameter int K     = 16,
    parameter int IDX_W = 20,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [IDX_W-1:0] push_val,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [IDX_W-1:0] rd_val
);
    logic [IDX_W-1:0] ent [K];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < K; i++) ent[i] <= '0;
        end else if (push) begin
            ent[0] <= push_val;
            for (int i = 1; i < K; i++) ent[i] <= ent[i-1];
        end
    end

    assign rd_val = ent[rd_sel];
endmodule

// File: rtl/vid_index_decoder.sv
module vid_index_decoder
    import vid_pkg::*;
#(
    parameter int K     = 16,
    parameter int HMAX  = 8,
    parameter int IDX_W = 20,
    parameter int IN_W  = 8,
    parameter int SYM_W = $clog2(K + 2),
    parameter int LEN_W = $clog2(HMAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             tbl_we,
    input  logic [HMAX-1:0]  tbl_addr,
    input  logic [SYM_W-1:0] tbl_sym,
    input  logic [LEN_W-1:0] tbl_len,
    output logic [IDX_W-1:0] out_idx,
    output logic             out_valid,
    input  logic             out_ready
);
    localparam int TOP_W = (IDX_W > HMAX) ? IDX_W : HMAX;
    localparam int BUF_W = TOP_W + IN_W;
    localparam int CNT_W = $clog2(BUF_W + 1);
    localparam int SEL_W = $clog2(K);
    localparam int RW_W  = $clog2(IDX_W + 1);

    dec_state_e       state, state_n;
    logic [TOP_W-1:0] win_top;
    logic [CNT_W-1:0] avail, take_n;
    logic [SYM_W-1:0] t_sym;
    logic [LEN_W-1:0] t_len;
    logic [IDX_W-1:0] next_id, slot_val, field_val, emit_val, push_val;
    logic [RW_W-1:0]  field_w;
    logic             sym_ok, field_ok, slot_free, emit, push, id_inc;

    vid_code_table #(.HMAX(HMAX), .SYM_W(SYM_W), .LEN_W(LEN_W)) table_i (
        .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wsym(tbl_sym), .wlen(tbl_len),
        .raddr(win_top[TOP_W-1 -: HMAX]), .rsym(t_sym), .rlen(t_len)
    );

    vid_bit_window #(.IN_W(IN_W), .BUF_W(BUF_W), .TOP_W(TOP_W), .CNT_W(CNT_W)) window_i (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .take_n(take_n), .win_top(win_top), .avail(avail)
    );

    vid_index_fifo #(.K(K), .IDX_W(IDX_W), .SEL_W(SEL_W)) fifo_i (
        .clk(clk), .rst(rst), .push(push), .push_val(push_val),
        .rd_sel(t_sym[SEL_W-1:0]), .rd_val(slot_val)
    );

    // Width of the explicit reload field: ceil(log2 g), at least 1.
    function automatic logic [RW_W-1:0] field_width(input logic [IDX_W-1:0] g);
        logic [RW_W-1:0] w;
        w = RW_W'(1);
        for (int i = 1; i < IDX_W; i++) begin
            if (32'(g) > (32'd1 << i)) w = RW_W'(i + 1);
        end
        return w;
    endfunction

    assign field_w   = field_width(next_id);
    assign field_val = win_top[TOP_W-1 -: IDX_W] >> (RW_W'(IDX_W) - field_w);
    assign sym_ok    = (t_len != '0) && (avail >= CNT_W'(t_len));
    assign field_ok  = avail >= CNT_W'(field_w);
    assign slot_free = !out_valid || out_ready;

    always_comb begin
        state_n  = state;
        take_n   = '0;
        emit     = 1'b0;
        emit_val = '0;
        push     = 1'b0;
        push_val = '0;
        id_inc   = 1'b0;
        unique case (state)
            SYM_WAIT: begin
                if (sym_ok) begin
                    if (t_sym < SYM_W'(K)) begin
                        if (slot_free) begin
                            take_n   = CNT_W'(t_len);
                            emit     = 1'b1;
                            emit_val = slot_val;
                        end
                    end else if (t_sym == SYM_W'(K)) begin
                        if (slot_free) begin
                            take_n   = CNT_W'(t_len);
                            emit     = 1'b1;
                            emit_val = next_id;
                            push     = 1'b1;
                            push_val = next_id;
                            id_inc   = 1'b1;
                        end
                    end else if (t_sym == SYM_W'(K + 1)) begin
                        take_n  = CNT_W'(t_len);
                        state_n = FIELD_WAIT;
                    end else begin
                        take_n = CNT_W'(t_len);
                    end
                end
            end
            FIELD_WAIT: begin
                if (field_ok && slot_free) begin
                    take_n   = CNT_W'(field_w);
                    emit     = 1'b1;
                    emit_val = field_val;
                    push     = 1'b1;
                    push_val = field_val;
                    state_n  = SYM_WAIT;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SYM_WAIT;
        else     state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_idx   <= '0;
            next_id   <= '0;
        end else begin
            if (emit) begin
                out_valid <= 1'b1;
                out_idx   <= emit_val;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
            if (id_inc) next_id <= next_id + 1'b1;
        end
    end
endmodule

// File: rtl/vid_index_decoder_chk.sv
module vid_index_decoder_chk #(
    parameter int IDX_W = 20,
    parameter int BUF_W = 28,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             out_valid,
    input logic             out_ready,
    input logic [IDX_W-1:0] out_idx,
    input logic [IDX_W-1:0] next_id,
    input logic [CNT_W-1:0] avail
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_idx)));

    // R2
    id_step_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (next_id == $past(next_id)) || (next_id == $past(next_id) + 1'b1));

    // R2
    id_emit_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (next_id != $past(next_id)) |-> (out_valid && out_idx == $past(next_id)));

    // R10
    win_bound_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        avail <= CNT_W'(BUF_W));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && next_id == '0 && avail == '0));
endmodule

bind vid_index_decoder vid_index_decoder_chk #(
    .IDX_W(IDX_W), .BUF_W(BUF_W), .CNT_W(CNT_W)
) chk_i (
    .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
    .out_idx(out_idx), .next_id(next_id), .avail(avail)
);

// File: tb/vid_index_decoder_tb.sv
`timescale 1ns/1ps
module vid_index_decoder_tb_top;
    localparam int K = 16, HMAX = 8, IDX_W = 20, IN_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [IN_W-1:0]  in_data = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic             tbl_we = 1'b0;
    logic [HMAX-1:0]  tbl_addr = '0;
    logic [4:0]       tbl_sym = '0;
    logic [3:0]       tbl_len = '0;
    logic [IDX_W-1:0] out_idx;
    logic             out_valid;
    logic             out_ready = 1'b0;

    always #4 clk = ~clk;

    vid_index_decoder #(.K(K), .HMAX(HMAX), .IDX_W(IDX_W), .IN_W(IN_W)) dut_i (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_sym(tbl_sym), .tbl_len(tbl_len),
        .out_idx(out_idx), .out_valid(out_valid), .out_ready(out_ready)
    );

    int checks = 0;
    int failures = 0;

    // Stream model: codes are slot = 0ssss, first-use = 10, reload = 11.
    bit              bitmem [0:16383];
    int              nb;
    logic [IDX_W-1:0] exp_idx [0:2047];
    int              exp_kind [0:2047];
    int              ne;
    int              mg;
    logic [IDX_W-1:0] mc [0:K-1];

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic put_bits(input int val, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            bitmem[nb] = val[i];
            nb++;
        end
    endtask

    task automatic model_push(input logic [IDX_W-1:0] v);
        for (int i = K - 1; i > 0; i--) mc[i] = mc[i-1];
        mc[0] = v;
    endtask

    function automatic int fw(input int g);
        int w = 1;
        while ((1 << w) < g) w++;
        return w;
    endfunction

    task automatic model_clear();
        nb = 0; ne = 0; mg = 0;
        for (int i = 0; i < K; i++) mc[i] = '0;
    endtask

    task automatic op_first();
        put_bits(2, 2);
        exp_idx[ne] = IDX_W'(mg); exp_kind[ne] = 2; ne++;
        model_push(IDX_W'(mg));
        mg++;
    endtask

    task automatic op_slot(input int s);
        put_bits(s, 5);
        exp_idx[ne] = mc[s]; exp_kind[ne] = 3; ne++;
    endtask

    task automatic op_reload(input int v);
        put_bits(3, 2);
        put_bits(v, fw(mg));
        exp_idx[ne] = IDX_W'(v); exp_kind[ne] = 4; ne++;
        model_push(IDX_W'(v));
    endtask

    function automatic string kind_tag(input int k);
        case (k)
            2: return "R2 first-use (R1)";
            3: return "R3 slot hit (R5 R6)";
            default: return "R4 reload field (R7)";
        endcase
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        // R8: reset state visible at the ports
        chk(!out_valid, "R8 out_valid in reset", out_valid, 0);
        chk(in_ready, "R8 in_ready in reset", in_ready, 1);
        rst = 1'b0;
    endtask

    task automatic run_stream(input int rpct, input int vpct, input int stall);
        int nw = (nb + IN_W - 1) / IN_W;
        int wi = 0, got = 0, cyc = 0;
        bit prev_stall = 0;
        logic [IDX_W-1:0] prev_idx = '0;
        logic [IN_W-1:0] w;
        while (got < ne && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (prev_stall)
                chk(out_valid && out_idx == prev_idx, "R9 hold under backpressure", out_idx, prev_idx);
            if (stall > 0 && cyc == stall)
                chk(!in_ready, "R10 in_ready low when window full", in_ready, 0);
            out_ready = (cyc <= stall) ? 1'b0 : (($urandom % 100) < rpct);
            w = '0;
            for (int b = 0; b < IN_W; b++)
                if (wi * IN_W + b < nb) w[IN_W-1-b] = bitmem[wi * IN_W + b];
            in_data = w;
            in_valid = (wi < nw) && ((cyc <= stall) || (($urandom % 100) < vpct));
            if (in_valid && in_ready) wi++;
            if (out_valid && out_ready) begin
                chk(out_idx == exp_idx[got], kind_tag(exp_kind[got]), out_idx, exp_idx[got]);
                got++;
            end
            prev_stall = out_valid && !out_ready;
            prev_idx = out_idx;
        end
        chk(got == ne, "R7 stream completed", got, ne);
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        // R1: code table load
        for (int a = 0; a < (1 << HMAX); a++) begin
            @(negedge clk);
            tbl_we = 1'b1;
            tbl_addr = HMAX'(a);
            if (a < 128)      begin tbl_sym = 5'(a >> 3); tbl_len = 4'd5; end
            else if (a < 192) begin tbl_sym = 5'd16;      tbl_len = 4'd2; end
            else              begin tbl_sym = 5'd17;      tbl_len = 4'd2; end
        end
        @(negedge clk);
        tbl_we = 1'b0;

        // Sweep: empty-cache slots, reloads at g=0/1, widths 1..6, every slot
        model_clear();
        op_slot(5);
        op_reload(1);
        op_reload(0);
        for (int t = 0; t < 40; t++) begin
            op_first();
            op_reload((t * 7) % mg);
            op_slot(t % K);
            op_slot(K - 1 - (t % K));
        end
        for (int s = 0; s < K; s++) op_slot(s);
        for (int s = 0; s < K; s++) op_slot(K - 1 - s);
        run_stream(50, 70, 0);

        // Backpressure fill: R9 and R10
        do_reset();
        model_clear();
        for (int t = 0; t < 30; t++) op_first();
        for (int s = 0; s < K; s++) op_slot(s);
        run_stream(80, 100, 60);

        // Restart after reset: counter and FIFO start over (R8)
        do_reset();
        model_clear();
        op_first();
        op_first();
        op_first();
        op_slot(0);
        op_slot(2);
        op_slot(3);
        op_reload(2);
        op_slot(0);
        run_stream(100, 100, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule